// File: doc/BRIEF.md
# Stack Push/Pop Bus Cycle Sequencer

This block drives the memory bus for an 8-bit processor's two-byte stack instructions that move a 16-bit index register. Decode has already happened by the time the block runs. A start pulse comes in with a direction select, the register value to store and the address of the instruction bytes. The block then runs a fixed sequence of four machine cycles, each three T-states long. The first two machine cycles fetch the opcode and the second code byte as ordinary reads whose data is thrown away. The last two move the data bytes between the bus and the stack.

The block owns the 16-bit stack pointer. A push moves the pointer down one byte before each write and stores the upper byte first. A pop reads the lower byte at the pointer, then the upper byte one address above, and leaves the pointer two higher than it was. All bus strobes are active low. The assembled pop word is presented together with a one-cycle completion pulse.

Top module: `stk_xfer_seq`

## Requirements
- R1: While reset is high, and whenever the block is idle, mreq_n_o, rd_n_o, wr_n_o and m1_n_o are 1, dout_oe_o, busy_o and done_o are 0, and addr_o and dout_o are 0. Reset loads sp_o with SP_INIT (default 0x0000).
- R2: A start_i sampled high while idle is accepted at that clock edge. busy_o is 1 for the following 12 cycles, which are machine cycles MC1 to MC4 in order, each made of T-states T1, T2 and T3. start_i has no effect while busy_o is 1, and it may be accepted again in the cycle in which done_o is high.
- R3: MC1 places the captured fetch_addr_i on addr_o and MC2 places fetch_addr_i+1 there. Both are read cycles, and the data returned in them affects neither pop_word_o nor sp_o.
- R4: In every machine cycle, addr_o is valid from T1 and stays unchanged through T3. mreq_n_o is 0 in T2 and T3 only. rd_n_o is 0 alongside it in read cycles and wr_n_o is 0 alongside it in write cycles. rd_n_o and wr_n_o are never 0 together.
- R5: A pop (pop_sel_i=1) reads at the stack pointer in MC3 and at stack pointer+1 in MC4. In each of these cycles din_i is sampled at the clock edge that ends T3. The MC3 byte becomes bits [7:0] of the result and the MC4 byte becomes bits [15:8].
- R6: When a pop completes, sp_o equals its starting value plus 2, modulo 2^16.
- R7: A push (pop_sel_i=0) lowers the stack pointer by one as MC3 begins and writes reg_val_i[15:8] at the new value. It lowers the pointer by one again as MC4 begins and writes reg_val_i[7:0] there. dout_o is valid and dout_oe_o is 1 from T1 through T3 of both write cycles.
- R8: done_o is high for exactly one cycle, the cycle after the edge that ends MC4 T3, and busy_o is 0 in that cycle. After a pop, pop_word_o holds the assembled word from that cycle until the next pop completes.
- R9: Stack pointer and address arithmetic wraps modulo 2^16. A push from 0x0000 writes at 0xFFFF and then at 0xFFFE.
- R10: m1_n_o is 0 in all three T-states of MC1 and 1 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction sequence when idle |
| pop_sel_i | input | 1 | 1 = pop, 0 = push |
| reg_val_i | input | 16 | Register value to push, captured at start |
| fetch_addr_i | input | 16 | Address of the opcode byte, captured at start |
| din_i | input | 8 | Read data from memory |
| addr_o | output | 16 | Address bus |
| dout_o | output | 8 | Write data |
| dout_oe_o | output | 1 | Write data drive enable |
| mreq_n_o | output | 1 | Memory request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| m1_n_o | output | 1 | Opcode fetch marker, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_word_o | output | 16 | Assembled pop result |
| sp_o | output | 16 | Current stack pointer |

## Verification
The start edge is counted as cycle 0. Cycle k, for k from 1 to 12, is T-state (k-1)%3 of machine cycle (k-1)/3. Each strobe, the address and the write data are therefore due in a cycle that the bench's reference model computes from the same count. The model compares all outputs at the falling edge of every clock, so it never samples at the edge where a register changes. Each pop byte must be taken from the memory model at the edge that ends T3 of its cycle. The pop word, the updated pointer and done_o are due together in cycle 13. Pointer decrements for a push must already be visible in T1 of MC3 and MC4.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Machine cycles of one stack instruction, in bus order
    typedef enum logic [1:0] {
        MC_OPC  = 2'd0,   // opcode fetch
        MC_PFX  = 2'd1,   // second code byte fetch
        MC_DAT1 = 2'd2,   // first data byte
        MC_DAT2 = 2'd3    // second data byte
    } mcyc_e;

    // T-states inside one machine cycle
    typedef enum logic [1:0] {
        TS_1 = 2'd0,
        TS_2 = 2'd1,
        TS_3 = 2'd2
    } tst_e;

    localparam int N_MCYC  = 4;
    localparam int N_TST   = 3;
    localparam int SEQ_LEN = N_MCYC * N_TST;

    typedef struct packed {
        logic  active;
        logic  is_pop;
        mcyc_e mc;
        tst_e  ts;
    } seq_state_t;

    // Internal active-high bus controls
    typedef struct packed {
        logic mreq;
        logic rd;
        logic wr;
        logic m1;
        logic oe;
    } bus_ctl_t;

    function automatic logic cyc_is_read(mcyc_e mc, logic is_pop);
        return (mc == MC_OPC) || (mc == MC_PFX) || is_pop;
    endfunction

    function automatic logic strobe_phase(tst_e ts);
        return ts != TS_1;
    endfunction

    function automatic mcyc_e mc_next(mcyc_e mc);
        return mcyc_e'(mc + 2'd1);
    endfunction

    function automatic tst_e ts_next(tst_e ts);
        return tst_e'(ts + 2'd1);
    endfunction

endpackage

// File: rtl/stk_tgen.sv
module stk_tgen
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       pop_sel_i,
    output seq_state_t st_o,
    output logic       accept_o,
    output logic       end_mc_o,
    output logic       done_o
);

    seq_state_t st_q;
    logic       done_q;

    assign accept_o = !st_q.active && start_i;
    assign end_mc_o = st_q.active && (st_q.ts == TS_3);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.is_pop <= 1'b0;
            st_q.mc     <= MC_OPC;
            st_q.ts     <= TS_1;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                st_q.active <= 1'b1;
                st_q.is_pop <= pop_sel_i;
                st_q.mc     <= MC_OPC;
                st_q.ts     <= TS_1;
            end else if (end_mc_o) begin
                st_q.ts <= TS_1;
                if (st_q.mc == MC_DAT2) begin
                    st_q.active <= 1'b0;
                    st_q.mc     <= MC_OPC;
                    done_q      <= 1'b1;
                end else begin
                    st_q.mc <= mc_next(st_q.mc);
                end
            end else if (st_q.active) begin
                st_q.ts <= ts_next(st_q.ts);
            end
        end
    end

    assign st_o   = st_q;
    assign done_o = done_q;

endmodule

// File: rtl/stk_spu.sv
module stk_spu
    import stk_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              is_pop_i,
    input  mcyc_e             mc_i,
    input  logic              accept_i,
    input  logic              end_mc_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] fa_q;
    logic              pre_dec;
    logic              post_inc;

    // Push lowers SP when entering each data cycle; pop adds two at the end
    assign pre_dec  = end_mc_i && !is_pop_i && ((mc_i == MC_PFX) || (mc_i == MC_DAT1));
    assign post_inc = end_mc_i &&  is_pop_i &&  (mc_i == MC_DAT2);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_INIT;
            fa_q <= '0;
        end else begin
            if (accept_i)
                fa_q <= fetch_addr_i;
            if (pre_dec)
                sp_q <= sp_q - ONE;
            else if (post_inc)
                sp_q <= sp_q + TWO;
        end
    end

    always_comb begin
        addr_o = '0;
        if (active_i) begin
            unique case (mc_i)
                MC_OPC:  addr_o = fa_q;
                MC_PFX:  addr_o = fa_q + ONE;
                MC_DAT1: addr_o = sp_q;
                MC_DAT2: addr_o = is_pop_i ? (sp_q + ONE) : sp_q;
                default: addr_o = '0;
            endcase
        end
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/stk_bus.sv
module stk_bus
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        st_i,
    input  logic              accept_i,
    input  logic              end_mc_i,
    input  logic [WORD_W-1:0] reg_val_i,
    input  logic [DATA_W-1:0] din_i,
    output bus_ctl_t          ctl_o,
    output logic [DATA_W-1:0] dout_o,
    output logic [WORD_W-1:0] pop_word_o
);

    logic [WORD_W-1:0] val_q;
    logic [DATA_W-1:0] lo_q;
    logic [WORD_W-1:0] word_q;
    logic              rd_cyc;
    logic              strobe;

    assign rd_cyc = cyc_is_read(st_i.mc, st_i.is_pop);
    assign strobe = st_i.active && strobe_phase(st_i.ts);

    always_comb begin
        ctl_o.mreq = strobe;
        ctl_o.rd   = strobe && rd_cyc;
        ctl_o.wr   = strobe && !rd_cyc;
        ctl_o.m1   = st_i.active && (st_i.mc == MC_OPC);
        ctl_o.oe   = st_i.active && !rd_cyc;
    end

    always_comb begin
        dout_o = '0;
        if (ctl_o.oe)
            dout_o = (st_i.mc == MC_DAT1) ? val_q[WORD_W-1:DATA_W] : val_q[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            lo_q   <= '0;
            word_q <= '0;
        end else begin
            if (accept_i)
                val_q <= reg_val_i;
            if (end_mc_i && st_i.is_pop) begin
                if (st_i.mc == MC_DAT1)
                    lo_q <= din_i;
                else if (st_i.mc == MC_DAT2)
                    word_q <= {din_i, lo_q};
            end
        end
    end

    assign pop_word_o = word_q;

endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
    import stk_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  pop_sel_i,
    input  logic [2*DATA_W-1:0]   reg_val_i,
    input  logic [ADDR_W-1:0]     fetch_addr_i,
    input  logic [DATA_W-1:0]     din_i,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [DATA_W-1:0]     dout_o,
    output logic                  dout_oe_o,
    output logic                  mreq_n_o,
    output logic                  rd_n_o,
    output logic                  wr_n_o,
    output logic                  m1_n_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*DATA_W-1:0]   pop_word_o,
    output logic [ADDR_W-1:0]     sp_o
);

    seq_state_t st;
    bus_ctl_t   ctl;
    logic       accept;
    logic       end_mc;

    stk_tgen u_tgen (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .pop_sel_i (pop_sel_i),
        .st_o      (st),
        .accept_o  (accept),
        .end_mc_o  (end_mc),
        .done_o    (done_o)
    );

    stk_spu #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_spu (
        .clk          (clk),
        .rst          (rst),
        .active_i     (st.active),
        .is_pop_i     (st.is_pop),
        .mc_i         (st.mc),
        .accept_i     (accept),
        .end_mc_i     (end_mc),
        .fetch_addr_i (fetch_addr_i),
        .sp_o         (sp_o),
        .addr_o       (addr_o)
    );

    stk_bus #(.DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .st_i       (st),
        .accept_i   (accept),
        .end_mc_i   (end_mc),
        .reg_val_i  (reg_val_i),
        .din_i      (din_i),
        .ctl_o      (ctl),
        .dout_o     (dout_o),
        .pop_word_o (pop_word_o)
    );

    assign mreq_n_o  = !ctl.mreq;
    assign rd_n_o    = !ctl.rd;
    assign wr_n_o    = !ctl.wr;
    assign m1_n_o    = !ctl.m1;
    assign dout_oe_o = ctl.oe;
    assign busy_o    = st.active;

endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mreq_n_o,
    input logic              rd_n_o,
    input logic              wr_n_o,
    input logic              m1_n_o,
    input logic              dout_oe_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] sp_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (mreq_n_o && rd_n_o && wr_n_o && m1_n_o && !dout_oe_o));

    assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    assert_strobe_has_mreq_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o || !wr_n_o) |-> !mreq_n_o);

    assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
        !mreq_n_o |-> $stable(addr_o));

    assert_write_at_sp_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> (addr_o == sp_o && dout_oe_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_m1_is_read_R10: assert property (@(posedge clk) disable iff (rst)
        !m1_n_o |-> (wr_n_o && !dout_oe_o && busy_o));

endmodule

bind stk_xfer_seq stk_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mreq_n_o  (mreq_n_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .m1_n_o    (m1_n_o),
    .dout_oe_o (dout_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .addr_o    (addr_o),
    .sp_o      (sp_o)
);

// File: tb/stk_xfer_seq_bench.sv
`timescale 1ns/1ps
module stk_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] val = '0;
    logic [15:0] fa = '0;
    logic [7:0]  din;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        oe, mreq_n, rd_n, wr_n, m1_n, busy, done;
    logic [15:0] pword, sp;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    stk_xfer_seq u_stk_xfer_seq (
        .clk(clk), .rst(rst), .start_i(start), .pop_sel_i(sel),
        .reg_val_i(val), .fetch_addr_i(fa), .din_i(din),
        .addr_o(addr), .dout_o(dout), .dout_oe_o(oe),
        .mreq_n_o(mreq_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .m1_n_o(m1_n),
        .busy_o(busy), .done_o(done), .pop_word_o(pword), .sp_o(sp)
    );

    // Memory model: 256 bytes, indexed by the low address byte
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 5) & 8'hFF);
    assign din = !rd_n ? mem[addr[7:0]] : 8'h00;
    always @(posedge clk) if (!rst && !wr_n && !mreq_n) mem[addr[7:0]] <= dout;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    bit          m_act, m_pop, m_done;
    int          m_k;
    logic [15:0] m_sp, m_val, m_fa, m_word;
    logic [7:0]  m_lo;
    logic [15:0] x_addr;
    logic [7:0]  x_dout;
    bit          x_strb, x_rd, x_m1, x_oe;

    always_comb begin
        int mc, ts;
        mc = m_k / 3;
        ts = m_k % 3;
        x_addr = 16'h0;
        x_strb = m_act && ts != 0;
        x_rd   = (mc < 2) || m_pop;
        x_m1   = m_act && mc == 0;
        x_oe   = m_act && !x_rd;
        x_dout = !x_oe ? 8'h00 : (mc == 2 ? m_val[15:8] : m_val[7:0]);
        if (m_act) begin
            case (mc)
                0: x_addr = m_fa;
                1: x_addr = m_fa + 16'd1;
                2: x_addr = m_sp;
                default: x_addr = m_pop ? m_sp + 16'd1 : m_sp;
            endcase
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_act = 0; m_pop = 0; m_done = 0; m_k = 0;
            m_sp = 16'h0000; m_val = '0; m_fa = '0; m_word = '0; m_lo = '0;
        end else begin
            m_done = 0;
            if (!m_act) begin
                if (start) begin
                    m_act = 1; m_k = 0; m_pop = sel; m_val = val; m_fa = fa;
                end
            end else begin
                if (m_pop && m_k == 8)  m_lo = mem[x_addr[7:0]];
                if (m_pop && m_k == 11) m_word = {mem[x_addr[7:0]], m_lo};
                if (!m_pop && (m_k == 5 || m_k == 8)) m_sp = m_sp - 16'd1;
                if (m_k == 11) begin
                    m_act = 0; m_done = 1; m_k = 0;
                    if (m_pop) m_sp = m_sp + 16'd2;
                end else begin
                    m_k++;
                end
            end
        end
    end

    // Compare every output at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            string ph;
            ph = !m_act ? "R1" : (m_k < 6 ? "R3" : (m_pop ? "R5" : "R7"));
            check(addr == x_addr, {ph, " addr"}, 32'(addr), 32'(x_addr));
            check(mreq_n == !x_strb, "R4 mreq_n", 32'(mreq_n), 32'(!x_strb));
            check(rd_n == !(x_strb && x_rd), "R4 rd_n", 32'(rd_n), 32'(!(x_strb && x_rd)));
            check(wr_n == !(x_strb && !x_rd), "R4 wr_n", 32'(wr_n), 32'(!(x_strb && !x_rd)));
            check(m1_n == !x_m1, "R10 m1_n", 32'(m1_n), 32'(!x_m1));
            check(oe == x_oe, "R7 dout_oe", 32'(oe), 32'(x_oe));
            check(dout == x_dout, "R7 dout", 32'(dout), 32'(x_dout));
            check(busy == m_act, "R2 busy", 32'(busy), 32'(m_act));
            check(done == m_done, "R8 done", 32'(done), 32'(m_done));
            check(pword == m_word, "R8 pop_word", 32'(pword), 32'(m_word));
            check(sp == m_sp, "R6 sp", 32'(sp), 32'(m_sp));
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) if (cyc > 5000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
        finish_run();
    end

    task automatic run_op(input bit pop, input logic [15:0] v, input logic [15:0] f);
        @(negedge clk);
        start = 1'b1; sel = pop; val = v; fa = f;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is still high
        check(mreq_n && rd_n && wr_n && m1_n && !oe && !busy && !done, "R1 strobes idle",
              32'({mreq_n, rd_n, wr_n, m1_n, oe, busy, done}), 32'b1111000);
        check(sp == 16'h0000, "R1 sp reset", 32'(sp), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Push from 0x0000: wraps (R9), high byte first (R7)
        run_op(1'b0, 16'hA55A, 16'h0040);
        check(done == 1'b1, "R8 done after push", 32'(done), 32'h1);
        check(sp == 16'hFFFE, "R9 sp after push", 32'(sp), 32'hFFFE);
        check(mem[8'hFF] == 8'hA5, "R7 high byte at sp-1", 32'(mem[8'hFF]), 32'hA5);
        check(mem[8'hFE] == 8'h5A, "R7 low byte at sp-2", 32'(mem[8'hFE]), 32'h5A);

        // Pop it back, crossing 0xFFFF -> 0x0000 (R5, R6, R9)
        run_op(1'b1, 16'h0000, 16'h0100);
        check(pword == 16'hA55A, "R5 pop word", 32'(pword), 32'hA55A);
        check(sp == 16'h0000, "R6 sp after pop", 32'(sp), 32'h0);

        // Pop from 0: low byte at 0, high byte at 1; fetch data ignored (R3)
        run_op(1'b1, 16'hFFFF, 16'h0002);
        check(pword == {8'((1*37+5)&8'hFF), 8'(5)}, "R5 pop from zero", 32'(pword),
              32'({8'((1*37+5)&8'hFF), 8'(5)}));
        check(sp == 16'h0002, "R6 sp plus two", 32'(sp), 32'h2);

        // Push with a stray start while busy (R2): must be ignored
        @(negedge clk);
        start = 1'b1; sel = 1'b0; val = 16'h1234; fa = 16'h0010;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; sel = 1'b1; val = 16'hDEAD;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        check(sp == 16'h0000, "R2 stray start ignored, sp", 32'(sp), 32'h0);
        check(mem[8'h01] == 8'h12 && mem[8'h00] == 8'h34, "R7 push 1234",
              32'({mem[8'h01], mem[8'h00]}), 32'h1234);
        @(negedge clk);
        check(!busy, "R2 no restart from stray start", 32'(busy), 32'h0);

        // Back-to-back pops with start held high (R2, R8)
        @(negedge clk);
        start = 1'b1; sel = 1'b1; fa = 16'h0080;
        repeat (30) @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(!busy && !done, "R2 idle at end", 32'({busy, done}), 32'h0);

        finish_run();
    end

endmodule